// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one timer channel behind a 32-bit word-register port. Software loads a terminal count into a 28-bit limit register and a clock divider and mode into the control register. It then sets the run bit. A prescaler turns every N system clocks into one count tick. The counter climbs on each tick. When the value it would step to equals the terminal count, the counter goes back to zero and a sticky pending flag is raised.

In repeat mode the channel keeps running, so the ticks it emits are evenly spaced. In one-shot mode the hardware drops the run bit after the first event. The interrupt line follows the pending flag, masked by an enable bit held in the same interrupt register. Software clears the pending flag by writing a one to it.

Registers are selected by `addr_i[3:2]`. Data reads are combinational and are valid in the same cycle as the request. Writes take effect at the clock edge where `req_i` and `we_i` are both high.

Top module: `tmr_channel`

## Requirements
- R1: After reset, all four registers read 0 and `irq_o` is low.
- R2: The registers sit at these byte offsets: limit at 0x0, count at 0x4, control at 0x8, interrupt at 0xC. Control bit 28 is run, bit 24 is repeat, and bits 15:0 are the divider N. If the run bit is written at clock edge k with count 0, limit T ≥ 0x20 and N ≥ 2, the pending flag is visible just after edge k + T·N.
- R3: A divider value of 0 or 1 behaves exactly like a divider of 2.
- R4: In one-shot mode (bit 24 = 0), an event leaves the count at 0 and clears the run bit. The divider and repeat fields read back unchanged.
- R5: In repeat mode (bit 24 = 1), the run bit stays set and events recur every T·N clocks.
- R6: Interrupt register bit 16 is the pending flag and bit 20 is the enable. `irq_o` is high exactly when both are set.
- R7: Writing 1 to bit 16 clears the pending flag. Writing 0 to it leaves the flag unchanged.
- R8: If a clear of the pending flag lands on the same edge as a new event, the flag stays set.
- R9: Writing 0 to the control register stops counting at once. The count holds its value, and a set pending flag stays set.
- R10: A write to the count register loads the live counter, and the register reads back the live value. Counting resumes from the loaded value.
- R11: Bits with no defined meaning read as 0. The limit and count registers are 28 bits wide, and control reads back only bits 28, 24 and 15:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Byte address; bits 3:2 select the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| irq_o | output | 1 | Pending AND enable |

## Verification
The period is measured in clocks from the run write to the interrupt, for several limit and divider pairs. A pair with an odd divider exposes off-by-one errors in the prescaler. Divider values 0 and 1, compared against 2, show whether the clamp is applied. A count preloaded one step below the limit separates "value reaches the limit" from "value passes the limit". A pending clear timed onto the edge of an event shows which of the two updates wins. One-shot and repeat runs are told apart by whether the run bit and a second event survive the first event.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W = 32;
  localparam logic [1:0] SEL_LIMIT = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;
  localparam logic [1:0] SEL_IRQ   = 2'd3;
  localparam int RUN_BIT  = 28;
  localparam int RPT_BIT  = 24;
  localparam int PEND_BIT = 16;
  localparam int IE_BIT   = 20;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] div_eff, ps_q;

  // divider below 2 is clamped to 2
  assign div_eff = (div_i < DIV_W'(2)) ? DIV_W'(2) : div_i;
  assign tick_o  = run_i && !clr_i && (ps_q == div_eff - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ps_q <= '0;
    else if (clr_i || !run_i)   ps_q <= '0;
    else if (tick_o)            ps_q <= '0;
    else                        ps_q <= ps_q + DIV_W'(1);
  end

  assert_tick_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 28,
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic             run_wr_i,
  input  logic             rpt_wr_i,
  input  logic [DIV_W-1:0] div_wr_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wr_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             run_o,
  output logic             rpt_o,
  output logic [DIV_W-1:0] div_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             event_o
);
  logic run_q, rpt_q, tick;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  tmr_prescaler #(.DIV_W(DIV_W)) u_ps (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run_q),
    .clr_i (ctrl_we_i || cnt_we_i),
    .div_i (div_q),
    .tick_o(tick)
  );

  assign cnt_nxt = cnt_q + CNT_W'(1);
  assign event_o = tick && (cnt_nxt == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      rpt_q <= 1'b0;
      div_q <= '0;
    end else if (ctrl_we_i) begin
      run_q <= run_wr_i;
      rpt_q <= rpt_wr_i;
      div_q <= div_wr_i;
    end else if (event_o && !rpt_q) begin
      run_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (cnt_we_i) cnt_q <= cnt_wr_i;
    else if (event_o)  cnt_q <= '0;
    else if (tick)     cnt_q <= cnt_nxt;
  end

  assign run_o = run_q;
  assign rpt_o = rpt_q;
  assign div_o = div_q;
  assign cnt_o = cnt_q;

  assert_oneshot_stop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_o && !rpt_q) |=> !run_q);
  assert_wrap_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_o && !cnt_we_i) |=> (cnt_q == '0));
  assert_repeat_keep_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_o && rpt_q && !ctrl_we_i) |=> run_q);
  assert_halt_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !cnt_we_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic clr_i,
  input  logic ie_wr_i,
  input  logic event_i,
  output logic pend_o,
  output logic ie_o,
  output logic irq_o
);
  logic pend_q, ie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      ie_q   <= 1'b0;
    end else begin
      if (we_i) ie_q <= ie_wr_i;
      // a new event outranks a same-cycle clear
      if (event_i)            pend_q <= 1'b1;
      else if (we_i && clr_i) pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
  assign ie_o   = ie_q;
  assign irq_o  = pend_q & ie_q;

  assert_event_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_i |=> pend_q);
  assert_pend_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !(we_i && clr_i)) |=> pend_q);
  assert_irq_mask_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ie_q && !we_i) |=> !irq_o);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 28,
  parameter int DIV_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [1:0] sel;
  logic wr_limit, wr_count, wr_ctrl, wr_irq;
  logic [CNT_W-1:0] limit_q, cnt;
  logic [DIV_W-1:0] div;
  logic run, rpt, evt, pend, ie;

  assign sel      = addr_i[3:2];
  assign wr_limit = req_i && we_i && (sel == SEL_LIMIT);
  assign wr_count = req_i && we_i && (sel == SEL_COUNT);
  assign wr_ctrl  = req_i && we_i && (sel == SEL_CTRL);
  assign wr_irq   = req_i && we_i && (sel == SEL_IRQ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       limit_q <= '0;
    else if (wr_limit) limit_q <= wdata_i[CNT_W-1:0];
  end

  tmr_counter #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctrl_we_i(wr_ctrl),
    .run_wr_i (wdata_i[RUN_BIT]),
    .rpt_wr_i (wdata_i[RPT_BIT]),
    .div_wr_i (wdata_i[DIV_W-1:0]),
    .cnt_we_i (wr_count),
    .cnt_wr_i (wdata_i[CNT_W-1:0]),
    .limit_i  (limit_q),
    .run_o    (run),
    .rpt_o    (rpt),
    .div_o    (div),
    .cnt_o    (cnt),
    .event_o  (evt)
  );

  tmr_irq u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_irq),
    .clr_i  (wdata_i[PEND_BIT]),
    .ie_wr_i(wdata_i[IE_BIT]),
    .event_i(evt),
    .pend_o (pend),
    .ie_o   (ie),
    .irq_o  (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_LIMIT: rdata_o[CNT_W-1:0] = limit_q;
      SEL_COUNT: rdata_o[CNT_W-1:0] = cnt;
      SEL_CTRL: begin
        rdata_o[RUN_BIT]     = run;
        rdata_o[RPT_BIT]     = rpt;
        rdata_o[DIV_W-1:0]   = div;
      end
      default: begin
        rdata_o[PEND_BIT] = pend;
        rdata_o[IE_BIT]   = ie;
      end
    endcase
  end

  assert_irq_needs_pend_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend && ie));
endmodule

// File: tb/tmr_channel_test.sv
module tmr_channel_test;
  localparam logic [3:0] A_LIM = 4'h0, A_CNT = 4'h4, A_CTL = 4'h8, A_IRQ = 4'hC;
  localparam logic [31:0] RUN = 32'h1000_0000, RPT = 32'h0100_0000;
  localparam logic [31:0] PEND = 32'h0001_0000, IEN = 32'h0010_0000;
  localparam int LIM = 5000;

  typedef struct packed {
    logic [27:0] term;
    logic [15:0] div;
    logic [31:0] cyc;
  } vec_t;
  localparam vec_t VEC [5] = '{
    '{28'h20, 16'd2, 32'd64},
    '{28'h21, 16'd3, 32'd99},
    '{28'h20, 16'd0, 32'd64},
    '{28'h20, 16'd1, 32'd64},
    '{28'h40, 16'd5, 32'd320}
  };

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, we = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq;
  int cyc = 0, tests = 0, fails = 0;
  bit done = 1'b0;

  tmr_channel uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", r, act, exp);
    end
  endtask

  // called at a negedge; write lands on the next posedge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_irq(input int start, output int n);
    while (!irq && (cyc - start) < LIM) @(negedge clk);
    n = cyc - start;
  endtask

  task automatic arm(input logic [27:0] t, input logic [31:0] ctl, output int start);
    wr(A_CTL, 32'h0);
    wr(A_IRQ, IEN | PEND);
    wr(A_CNT, 32'h0);
    wr(A_LIM, {4'h0, t});
    wr(A_CTL, ctl);
    start = cyc;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, a, b;
    int st, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_LIM, v); chk("R1 limit", v, 0);
    rd(A_CNT, v); chk("R1 count", v, 0);
    rd(A_CTL, v); chk("R1 ctrl", v, 0);
    rd(A_IRQ, v); chk("R1 irq reg", v, 0);
    chk("R1 irq_o", {31'h0, irq}, 0);

    // R11 undefined bits
    wr(A_LIM, 32'hFFFF_FFFF); rd(A_LIM, v); chk("R11 limit mask", v, 32'h0FFF_FFFF);
    wr(A_CTL, 32'hFFFF_FFFF); rd(A_CTL, v); chk("R11 ctrl mask", v, 32'h1100_FFFF);
    wr(A_CTL, 32'h0);
    wr(A_IRQ, 32'hFFFF_FFFF); rd(A_IRQ, v); chk("R11 irq mask", v, IEN);

    // R2 R3 R4 period table, one-shot
    foreach (VEC[i]) begin
      arm(VEC[i].term, RUN | {16'h0, VEC[i].div}, st);
      wait_irq(st, n);
      chk(i >= 2 && i <= 3 ? "R3 clamped period" : "R2 period", n, VEC[i].cyc);
      rd(A_CTL, v); chk("R4 run cleared", v, {16'h0, VEC[i].div});
      rd(A_CNT, v); chk("R4 count zero", v, 0);
    end

    // R5 repeat
    arm(28'h20, RUN | RPT | 32'd2, st);
    wait_irq(st, n); chk("R5 first event", n, 64);
    wr(A_IRQ, IEN | PEND);
    wait_irq(st, n); chk("R5 second event", n, 128);
    rd(A_CTL, v); chk("R5 run kept", v, RUN | RPT | 32'd2);

    // R6 R7 gating and clear
    wr(A_CTL, 32'h0); wr(A_IRQ, PEND);
    wr(A_CNT, 32'h0); wr(A_LIM, 32'h20); wr(A_CTL, RUN | 32'd2);
    repeat (70) @(negedge clk);
    chk("R6 masked irq_o", {31'h0, irq}, 0);
    rd(A_IRQ, v); chk("R6 pend bit16", v, PEND);
    wr(A_IRQ, IEN); chk("R6 irq_o on", {31'h0, irq}, 1);
    rd(A_IRQ, v); chk("R7 write0 keeps", v, PEND | IEN);
    wr(A_IRQ, IEN | PEND); chk("R7 w1c", {31'h0, irq}, 0);

    // R9 stop holds count and pending
    arm(28'h20, RUN | RPT | 32'd2, st);
    wait_irq(st, n);
    repeat (10) @(negedge clk);
    wr(A_CTL, 32'h0);
    rd(A_CNT, a);
    repeat (8) @(negedge clk);
    rd(A_CNT, b);
    chk("R9 count frozen", b, a);
    chk("R9 count moved", {31'h0, a != 0}, 1);
    rd(A_IRQ, v); chk("R9 pend kept", v, PEND | IEN);

    // R10 count load
    wr(A_CNT, 32'h123); rd(A_CNT, v); chk("R10 readback", v, 32'h123);
    wr(A_IRQ, IEN | PEND); wr(A_LIM, 32'h20); wr(A_CNT, 32'h1F);
    wr(A_CTL, RUN | 32'd2); st = cyc;
    wait_irq(st, n); chk("R10 resume from load", n, 2);

    // R8 clear on event edge
    arm(28'h20, RUN | 32'd2, st);
    while (cyc != st + 63) @(negedge clk);
    wr(A_IRQ, IEN | PEND);
    chk("R8 event wins", {31'h0, irq}, 1);
    rd(A_IRQ, v); chk("R8 pend set", v, PEND | IEN);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule